// File: doc/BRIEF.md
# Multi-Mode Timer Output Compare Channel

This channel watches one of two external free-running time-base counters and drives one output pin from it. Each cycle it compares the selected count against a primary and a secondary compare value. Depending on a 3-bit mode it can act in one of these ways:

- a one-shot event that drives the pin high, drives it low, or inverts it
- a rise-then-fall pulse, either once or on every period
- a PWM generator whose duty value is reloaded only at period boundaries

Each compare event raises a one-cycle interrupt request.

Software programs the channel through a narrow write port with three targets:

- a control word holding the mode, the time-base select and the idle-stop bit
- the primary compare value
- the secondary compare value

The counters supply a period-end strobe, which is high in the cycle where the count equals its period value, so the next count is zero. In the PWM variant with fault protection, a fault input latches a sticky flag. The flag forces the pin low and clears only on reset.

Top module: `ocmp_unit`

## Requirements
- R1: After reset, and in mode 000, the pin (`cmp_o`) and `irq_o` are low. In mode 000 no compare event is produced.
- R2: Mode 001 sets the pin low when the mode is loaded. The cycle after the selected count equals the primary value, the pin is high and `irq_o` pulses for one cycle.
- R3: Mode 010 sets the pin high when the mode is loaded. The cycle after a primary match, the pin is low and `irq_o` pulses.
- R4: Mode 011 sets the pin low when the mode is loaded. It inverts the pin and pulses `irq_o` after every primary match, including a primary value equal to the period, which toggles once per period.
- R5: Mode 100 starts low and armed. A primary match while low raises the pin. A secondary match while high lowers it, pulses `irq_o` and disarms, so the pulse occurs once.
- R6: Mode 101 behaves like mode 100 but never disarms, so the pulse repeats every period.
- R7: In modes 110 and 111, at a period-end strobe the active duty D is loaded from the secondary value, the pin is set to (D != 0) and `irq_o` pulses. The pin falls after the cycle whose count equals D-1. With period P, the pin is high for counts 0..D-1.
- R8: Entering a PWM mode loads the active duty from the primary value and sets the pin to (primary != 0). A duty of 0 keeps the pin low, and a duty above the period keeps it high.
- R9: In mode 111 an asserted `fault_i` sets `fault_o`, which stays set until reset. While `fault_o` is set in mode 111 the pin reads low. In mode 110, `fault_i` has no effect on `fault_o`.
- R10: Control bit 3 selects the time base: 0 selects counter A with its strobe, and 1 selects counter B with its strobe.
- R11: With control bit 4 set, a cycle with `idle_i` high produces no event and the pin holds its value. With bit 4 clear, `idle_i` is ignored.
- R12: `wr_sel_i` 0 writes the control word, with the mode in bits 2:0. `wr_sel_i` 1 writes the primary value and 2 writes the secondary value. A control write takes effect at the next edge, and the following cycle only loads the mode's initial state, with no compare event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 control, 1 primary, 2 secondary |
| wr_data_i | input | CNT_W | Write data |
| cnt_a_i | input | CNT_W | Counter A value |
| prd_a_i | input | 1 | Counter A period-end strobe |
| cnt_b_i | input | CNT_W | Counter B value |
| prd_b_i | input | 1 | Counter B period-end strobe |
| idle_i | input | 1 | Idle indication |
| fault_i | input | 1 | Fault input |
| cmp_o | output | 1 | Compare output pin |
| irq_o | output | 1 | One-cycle interrupt request |
| fault_o | output | 1 | Sticky fault status |

## Verification
The assertions check five properties on every cycle:

- mode 000 keeps the pin and the interrupt low
- the fault flag never clears
- a latched fault keeps the pin low in mode 111
- mode 110 never latches a fault
- an idle-stopped cycle leaves the pin unchanged and raises no interrupt

The exact cycle of each edge of the set, clear, toggle, pulse and PWM waveforms can only be shown by the bench's scenarios. The same holds for the once-only nature of mode 100, for the boundary-only reload of the duty value, and for which time base is in use. The bench sweeps every mode, both time bases and every primary and secondary value across the period range, and compares against an arithmetic model.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;
  typedef enum logic [2:0] {
    M_OFF    = 3'd0,
    M_SET    = 3'd1,
    M_CLR    = 3'd2,
    M_TGL    = 3'd3,
    M_PULSE1 = 3'd4,
    M_PULSEN = 3'd5,
    M_PWM    = 3'd6,
    M_PWMF   = 3'd7
  } mode_e;

  typedef struct packed {
    logic  idle_stop;
    logic  tsel;
    mode_e mode;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_PRI  = 2'd1;
  localparam logic [1:0] SEL_SEC  = 2'd2;
endpackage

// File: rtl/ocmp_regs.sv
module ocmp_regs
  import ocmp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [1:0]   wr_sel_i,
  input  logic [W-1:0] wr_data_i,
  output ctrl_t        ctrl_o,
  output logic [W-1:0] pri_o,
  output logic [W-1:0] sec_o,
  output logic         load_o
);
  ctrl_t        ctrl_q;
  logic [W-1:0] pri_q, sec_q;
  logic         load_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      pri_q  <= '0;
      sec_q  <= '0;
      load_q <= 1'b0;
    end else begin
      load_q <= wr_en_i && (wr_sel_i == SEL_CTRL);
      if (wr_en_i) begin
        unique case (wr_sel_i)
          SEL_CTRL: ctrl_q <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
          SEL_PRI:  pri_q  <= wr_data_i;
          SEL_SEC:  sec_q  <= wr_data_i;
          default:  ;
        endcase
      end
    end
  end

  assign ctrl_o = ctrl_q;
  assign pri_o  = pri_q;
  assign sec_o  = sec_q;
  assign load_o = load_q;
endmodule

// File: rtl/ocmp_tbsel.sv
module ocmp_tbsel #(
  parameter int W   = 8,
  parameter int NTB = 2,
  localparam int SW = (NTB > 1) ? $clog2(NTB) : 1
) (
  input  logic [NTB-1:0][W-1:0] cnt_i,
  input  logic [NTB-1:0]        prd_i,
  input  logic [SW-1:0]         sel_i,
  output logic [W-1:0]          cnt_o,
  output logic                  prd_o
);
  generate
    if (NTB == 1) begin : g_single
      logic unused_sel;
      assign unused_sel = ^sel_i;
      assign cnt_o = cnt_i[0];
      assign prd_o = prd_i[0];
    end else begin : g_mux
      always_comb begin
        cnt_o = cnt_i[0];
        prd_o = prd_i[0];
        for (int i = 1; i < NTB; i++) begin
          if (sel_i == SW'(i)) begin
            cnt_o = cnt_i[i];
            prd_o = prd_i[i];
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/ocmp_core.sv
module ocmp_core
  import ocmp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  ctrl_t        ctrl_i,
  input  logic [W-1:0] pri_i,
  input  logic [W-1:0] sec_i,
  input  logic         load_i,
  input  logic [W-1:0] cnt_i,
  input  logic         prd_i,
  input  logic         idle_i,
  input  logic         fault_i,
  output logic         out_o,
  output logic         irq_o,
  output logic         flt_o
);
  logic         out_q, irq_q, armed_q, flt_q;
  logic [W-1:0] duty_q;
  logic         run, pri_hit, sec_hit, duty_end;
  logic [W:0]   cnt_nxt;

  assign run      = !(ctrl_i.idle_stop && idle_i);
  assign pri_hit  = (cnt_i == pri_i);
  assign sec_hit  = (cnt_i == sec_i);
  assign cnt_nxt  = {1'b0, cnt_i} + 1'b1;
  // fall after the cycle whose count is duty-1
  assign duty_end = (cnt_nxt == {1'b0, duty_q});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q   <= 1'b0;
      irq_q   <= 1'b0;
      armed_q <= 1'b0;
      duty_q  <= '0;
      flt_q   <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (ctrl_i.mode == M_PWMF && fault_i) flt_q <= 1'b1;
      if (load_i) begin
        unique case (ctrl_i.mode)
          M_CLR: out_q <= 1'b1;
          M_PULSE1, M_PULSEN: begin
            out_q   <= 1'b0;
            armed_q <= 1'b1;
          end
          M_PWM, M_PWMF: begin
            out_q  <= (pri_i != '0);
            duty_q <= pri_i;
          end
          default: out_q <= 1'b0;
        endcase
      end else if (ctrl_i.mode == M_OFF) begin
        out_q <= 1'b0;
      end else if (run) begin
        unique case (ctrl_i.mode)
          M_SET: if (pri_hit) begin out_q <= 1'b1; irq_q <= 1'b1; end
          M_CLR: if (pri_hit) begin out_q <= 1'b0; irq_q <= 1'b1; end
          M_TGL: if (pri_hit) begin out_q <= !out_q; irq_q <= 1'b1; end
          M_PULSE1: begin
            if (armed_q) begin
              if (!out_q && pri_hit) out_q <= 1'b1;
              else if (out_q && sec_hit) begin
                out_q   <= 1'b0;
                armed_q <= 1'b0;
                irq_q   <= 1'b1;
              end
            end
          end
          M_PULSEN: begin
            if (!out_q && pri_hit) out_q <= 1'b1;
            else if (out_q && sec_hit) begin
              out_q <= 1'b0;
              irq_q <= 1'b1;
            end
          end
          M_PWM, M_PWMF: begin
            if (prd_i) begin
              duty_q <= sec_i;
              out_q  <= (sec_i != '0);
              irq_q  <= 1'b1;
            end else if (duty_end) begin
              out_q <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign out_o = out_q && !(flt_q && ctrl_i.mode == M_PWMF);
  assign irq_o = irq_q;
  assign flt_o = flt_q;
endmodule

// File: rtl/ocmp_unit.sv
module ocmp_unit
  import ocmp_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic [CNT_W-1:0] cnt_a_i,
  input  logic             prd_a_i,
  input  logic [CNT_W-1:0] cnt_b_i,
  input  logic             prd_b_i,
  input  logic             idle_i,
  input  logic             fault_i,
  output logic             cmp_o,
  output logic             irq_o,
  output logic             fault_o
);
  localparam int NTB = 2;

  ctrl_t                    ctrl;
  logic [CNT_W-1:0]         pri, sec, cnt_sel;
  logic                     load, prd_sel;
  logic [NTB-1:0][CNT_W-1:0] cnt_vec;
  logic [NTB-1:0]           prd_vec;

  assign cnt_vec = {cnt_b_i, cnt_a_i};
  assign prd_vec = {prd_b_i, prd_a_i};

  ocmp_regs #(.W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .ctrl_o(ctrl), .pri_o(pri), .sec_o(sec), .load_o(load)
  );

  ocmp_tbsel #(.W(CNT_W), .NTB(NTB)) u_tbsel (
    .cnt_i(cnt_vec), .prd_i(prd_vec), .sel_i(ctrl.tsel),
    .cnt_o(cnt_sel), .prd_o(prd_sel)
  );

  ocmp_core #(.W(CNT_W)) u_core (
    .clk_i, .rst_ni, .ctrl_i(ctrl), .pri_i(pri), .sec_i(sec),
    .load_i(load), .cnt_i(cnt_sel), .prd_i(prd_sel),
    .idle_i, .fault_i,
    .out_o(cmp_o), .irq_o(irq_o), .flt_o(fault_o)
  );
endmodule

// File: rtl/ocmp_unit_chk.sv
module ocmp_unit_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] mode_i,
  input logic       istop_i,
  input logic       load_i,
  input logic       idle_i,
  input logic       cmp_o,
  input logic       irq_o,
  input logic       fault_o
);
  // R1
  off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd0) |=> (!cmp_o && !irq_o));

  // R9
  flt_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> fault_o);

  // R9
  flt_force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && mode_i == 3'd7) |-> !cmp_o);

  // R9
  pwm_nofault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd6 && !fault_o) |=> !fault_o);

  // R11
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (istop_i && idle_i && !load_i && mode_i != 3'd7) |=> ($stable(cmp_o) && !irq_o));
endmodule

bind ocmp_unit ocmp_unit_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .mode_i  (ctrl.mode),
  .istop_i (ctrl.idle_stop),
  .load_i  (load),
  .idle_i  (idle_i),
  .cmp_o   (cmp_o),
  .irq_o   (irq_o),
  .fault_o (fault_o)
);

// File: tb/ocmp_unit_test.sv
module ocmp_unit_test;
  localparam int W  = 8;
  localparam int PA = 9;
  localparam int PB = 6;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_sel = '0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] cnt_a = '0, cnt_b = '0;
  logic         prd_a = 1'b0, prd_b = 1'b0;
  logic         idle = 1'b0, fault = 1'b0;
  logic         cmp, irq, flt;

  int errors = 0, checks = 0;
  int ca = 0, cb = 0, cyc = 0;

  // reference model state
  int m_mode, m_pri, m_sec, m_duty;
  bit m_tsel, m_istop, m_load, m_out, m_irq, m_armed, m_flt;

  always #2 clk = ~clk;

  ocmp_unit #(.CNT_W(W)) uut (
    .clk_i(clk), .rst_ni, .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .cnt_a_i(cnt_a), .prd_a_i(prd_a), .cnt_b_i(cnt_b), .prd_b_i(prd_b),
    .idle_i(idle), .fault_i(fault), .cmp_o(cmp), .irq_o(irq), .fault_o(flt)
  );

  function automatic string tag_of(int md, int sec, int per);
    case (md)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      6: return (sec == 0 || sec > per) ? "R8" : "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d (mode=%0d tsel=%0d cyc=%0d)",
               tag, what, act, exp, m_mode, m_tsel, cyc);
    end
  endtask

  task automatic model_reset();
    m_mode = 0; m_pri = 0; m_sec = 0; m_duty = 0;
    m_tsel = 0; m_istop = 0; m_load = 0; m_out = 0; m_irq = 0; m_armed = 0; m_flt = 0;
  endtask

  task automatic model_next(bit we, int sel, int data);
    int c, per;
    bit p;
    c   = m_tsel ? cb : ca;
    per = m_tsel ? PB : PA;
    p   = (c == per);
    m_irq = 0;
    if (m_load) begin
      case (m_mode)
        2: m_out = 1;
        4, 5: begin m_out = 0; m_armed = 1; end
        6, 7: begin m_out = (m_pri != 0); m_duty = m_pri; end
        default: m_out = 0;
      endcase
    end else if (m_mode == 0) begin
      m_out = 0;
    end else if (!(m_istop && idle)) begin
      case (m_mode)
        1: if (c == m_pri) begin m_out = 1; m_irq = 1; end
        2: if (c == m_pri) begin m_out = 0; m_irq = 1; end
        3: if (c == m_pri) begin m_out = !m_out; m_irq = 1; end
        4: if (m_armed) begin
             if (!m_out && c == m_pri) m_out = 1;
             else if (m_out && c == m_sec) begin m_out = 0; m_armed = 0; m_irq = 1; end
           end
        5: begin
             if (!m_out && c == m_pri) m_out = 1;
             else if (m_out && c == m_sec) begin m_out = 0; m_irq = 1; end
           end
        default: begin
             if (p) begin m_duty = m_sec; m_out = (m_sec != 0); m_irq = 1; end
             else if (c + 1 == m_duty) m_out = 0;
           end
      endcase
    end
    if (m_mode == 7 && fault) m_flt = 1;
    m_load = we && sel == 0;
    if (we) begin
      case (sel)
        0: begin m_mode = data & 7; m_tsel = data[3]; m_istop = data[4]; end
        1: m_pri = data;
        2: m_sec = data;
        default: ;
      endcase
    end
  endtask

  // one cycle: inputs applied at negedge, outputs checked at the next negedge
  task automatic step(bit we, int sel, int data);
    string t;
    bit eo;
    wr_en = we; wr_sel = sel[1:0]; wr_data = data[W-1:0];
    cnt_a = ca[W-1:0]; prd_a = (ca == PA);
    cnt_b = cb[W-1:0]; prd_b = (cb == PB);
    model_next(we, sel, data);
    @(negedge clk);
    wr_en = 0;
    t  = tag_of(m_mode, m_sec, m_tsel ? PB : PA);
    eo = m_out && !(m_flt && m_mode == 7);
    chk(cmp == eo, t, "cmp_o", cmp, eo);
    chk(irq == m_irq, t, "irq_o", irq, m_irq);
    chk(flt == m_flt, "R9", "fault_o", flt, m_flt);
    ca = (ca == PA) ? 0 : ca + 1;
    cb = (cb == PB) ? 0 : cb + 1;
    cyc++;
  endtask

  task automatic do_reset();
    rst_ni = 0; idle = 0; fault = 0; wr_en = 0;
    model_reset();
    @(negedge clk); @(negedge clk);
    chk(cmp == 0 && irq == 0 && flt == 0, "R1", "reset outputs", {cmp, irq, flt}, 0);
    rst_ni = 1;
  endtask

  initial begin
    #(4 * 190000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1: mode 000 with live counters, matching values and fault present
    step(1, 1, 3); step(1, 2, 5); step(1, 0, 0);
    for (int k = 0; k < 25; k++) begin
      fault = (k == 10);
      step(0, 0, 0);
    end
    fault = 0;
    // R2..R12: sweep of mode, time base, primary and secondary
    for (int ts = 0; ts < 2; ts++) begin
      for (int md = 1; md < 8; md++) begin
        for (int pr = 0; pr < 12; pr++) begin
          for (int sc = 0; sc < 12; sc++) begin
            int ctl;
            do_reset();
            ctl = md | (ts << 3) | ((sc % 2) << 4); // R10 bit3, R11 bit4, R12 mode bits
            step(1, 1, pr);
            step(1, 2, sc);
            step(1, 0, ctl);
            for (int k = 0; k < 30; k++) begin
              idle  = ((k % 7) >= 4);                 // R11 idle pattern
              fault = (k == 20) && (pr % 4 == 1);     // R9 fault pulse
              if (md >= 6 && k == 12) step(1, 2, (sc + 3) % 12); // R7 duty change mid-period
              else step(0, 0, 0);
            end
            idle = 0; fault = 0;
          end
        end
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule